// File: doc/BRIEF.md
# Code Boundary Regeneration Controller

This block re-encodes a memory from one error-correcting code to another while the memory stays live. It holds a boundary address. While the boundary is enabled, every access is tagged with the code that fits its side of the boundary: words below the boundary already hold the new code, and words at or above it still hold the old one. While the boundary is disabled, a global code select tags every access.

When boundary updating is enabled, a sequencer works upward from the boundary one word at a time. For each word it issues a locked read with the old code, keeps the decoded data, and issues a locked write of that data with the new code. It then moves the boundary up by one word. The codecs outside the block turn the read into data and the data into new check bits. Between words, other masters reach the memory through the same command port and have priority over the sequencer. Inside a locked pair they are held off. When the word at the top address has been rewritten, a done flag is set and an interrupt pulses once.

A single configuration write loads every control at once: the lane-substitution select, the boundary, the boundary enable, the update enable, the correctable-error mask and the global code select. While the mask is set, correctable errors that come back with read data raise no interrupt.

Top module: `code_boundary_regen`

## Requirements
- R1: After reset the boundary is 0, no memory command is valid, the lane select is 0, and the done flag and both interrupts are low.
- R2: One cycle with `cfg_we` high loads the lane select, the boundary, both enables, the error mask and the global code select together. They are visible on `lane_sel` and `boundary` on the next cycle.
- R3: With the boundary enabled, a host command to an address below `boundary` carries `mem_cmd_newcode`=1, and one at or above it carries 0.
- R4: With the boundary disabled, every host command carries `mem_cmd_newcode` equal to the global code select.
- R5: For each word, the sequencer issues a read of the boundary address with code 0. The next command is a write to the same address with code 1 and `mem_cmd_lock`=1, carrying the data returned for that read. The data of every word is preserved.
- R6: Between a sequencer read and its write-back, no host command is issued.
- R7: After each write-back the boundary goes up by exactly one, so the words are rewritten in ascending address order from the loaded boundary.
- R8: When the top address has been rewritten, `regen_done` goes to 1 and `regen_irq` pulses for one cycle. No further sequencer command follows and the boundary stays one past the top.
- R9: While regeneration runs, host reads and writes are still served with correct data.
- R10: A read response with `mem_rsp_ce`=1 pulses `ce_irq` one cycle later when the mask is clear. It raises nothing when the mask is set.
- R11: A host write issued during regeneration takes its code from the boundary at the cycle it is granted.
- R12: A configuration write cancels the word in progress and loads its boundary value. With update enable clear, the sequencer issues nothing more and the boundary holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_lane | input | LW | Lane-substitution select to load |
| cfg_bnd | input | AW | Boundary word address to load |
| cfg_bnd_en | input | 1 | Boundary enable to load |
| cfg_upd_en | input | 1 | Boundary update (regeneration) enable to load |
| cfg_ce_mask | input | 1 | Correctable-error mask to load |
| cfg_code_new | input | 1 | Global code select to load (1 = new code) |
| h_req | input | 1 | Host command request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | AW | Host word address |
| h_wdata | input | DW | Host write data |
| h_gnt | output | 1 | Host request accepted this cycle |
| h_rsp_valid | output | 1 | Host read data valid |
| h_rdata | output | DW | Host read data |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_we | output | 1 | Memory command is a write |
| mem_cmd_addr | output | AW | Memory command word address |
| mem_cmd_wdata | output | DW | Memory command write data |
| mem_cmd_newcode | output | 1 | Command uses the new code (1) or old (0) |
| mem_cmd_lock | output | 1 | Command belongs to a locked read/write pair |
| mem_cmd_seq | output | 1 | Command comes from the sequencer |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_seq | input | 1 | Response belongs to a sequencer read |
| mem_rsp_rdata | input | DW | Decoded read data |
| mem_rsp_ce | input | 1 | Response carried a correctable error |
| lane_sel | output | LW | Current lane-substitution select |
| boundary | output | AW+1 | Current boundary (one past the top when finished) |
| regen_done | output | 1 | Regeneration reached past the top address |
| regen_irq | output | 1 | One-cycle pulse when regeneration finishes |
| ce_irq | output | 1 | Unmasked correctable-error pulse |

## Verification
The hardest situation to reach is a host request that arrives while a sequencer word is half done. The locked read has gone out, its write-back is still pending, and the host address lies on one side or the other of a boundary that is moving. The bench starts a full regeneration and, in parallel, drives host writes and reads whose timing lands inside locked pairs and across the boundary. A bench memory records every command, keeps the data and code per word, and counts reads whose code differs from the stored one. A separate scenario cancels a walk partway with a configuration write.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RD, SQ_WAIT, SQ_WR} seq_state_e;
  typedef struct packed {
    logic bnd_en;
    logic upd_en;
    logic ce_mask;
    logic code_new;
  } cbr_mode_t;
endpackage

// File: rtl/cbr_cfg_reg.sv
`timescale 1ns/1ps
module cbr_cfg_reg #(
  parameter int AW       = 10,
  parameter int LW       = 3,
  parameter int TOP_ADDR = (1 << AW) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [LW-1:0]     cfg_lane,
  input  logic [AW-1:0]     cfg_bnd,
  input  cbr_pkg::cbr_mode_t cfg_mode,
  input  logic              adv,
  output logic [LW-1:0]     lane_sel,
  output logic [AW:0]       bnd,
  output logic              bnd_en,
  output logic              code_new,
  output logic              ce_mask,
  output logic              done,
  output logic              done_irq,
  output logic              active
);
  localparam logic [AW:0] TOP_B = (AW+1)'(TOP_ADDR);

  logic upd_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_sel <= '0;
      bnd      <= '0;
      bnd_en   <= 1'b0;
      upd_en   <= 1'b0;
      ce_mask  <= 1'b0;
      code_new <= 1'b0;
      done     <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (cfg_we) begin
        lane_sel <= cfg_lane;
        bnd      <= {1'b0, cfg_bnd};
        bnd_en   <= cfg_mode.bnd_en;
        upd_en   <= cfg_mode.upd_en;
        ce_mask  <= cfg_mode.ce_mask;
        code_new <= cfg_mode.code_new;
        done     <= 1'b0;
      end else if (adv) begin
        bnd <= bnd + 1'b1;
        if (bnd == TOP_B) begin
          done     <= 1'b1;
          done_irq <= 1'b1;
        end
      end
    end
  end

  assign active = bnd_en && upd_en && !done && (bnd <= TOP_B);

  // R7
  bnd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && !$past(rst) && bnd != $past(bnd)) |-> (bnd == $past(bnd) + 1'b1));

  // R8
  irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> done);

  // R8
  irq_once_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
endmodule

// File: rtl/cbr_regen_seq.sv
`timescale 1ns/1ps
module cbr_regen_seq #(
  parameter int AW = 10,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          active,
  input  logic [AW-1:0] bnd_lo,
  input  logic          gnt,
  input  logic          rsp_valid,
  input  logic          rsp_seq,
  input  logic [DW-1:0] rsp_data,
  output logic          req,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          lock,
  output logic          adv
);
  import cbr_pkg::*;

  seq_state_e    state;
  logic [DW-1:0] wbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      wbuf  <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (active && !abort) state <= SQ_RD;
        SQ_RD: begin
          if (abort)    state <= SQ_IDLE;
          else if (gnt) state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (abort) state <= SQ_IDLE;
          else if (rsp_valid && rsp_seq) begin
            wbuf  <= rsp_data;
            state <= SQ_WR;
          end
        end
        SQ_WR: begin
          if (abort)    state <= SQ_IDLE;
          else if (gnt) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign req       = (state == SQ_RD || state == SQ_WR) && !abort;
  assign req_we    = (state == SQ_WR);
  assign req_addr  = bnd_lo;
  assign req_wdata = wbuf;
  assign lock      = (state == SQ_WAIT || state == SQ_WR);
  assign adv       = (state == SQ_WR) && gnt && !abort;

  // R5
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_WR) |-> ($past(state) == SQ_WAIT || $past(state) == SQ_WR));
endmodule

// File: rtl/cbr_arb.sv
`timescale 1ns/1ps
module cbr_arb #(
  parameter int AW = 10,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_req,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic          seq_req,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [DW-1:0] seq_wdata,
  input  logic          lock,
  input  logic [AW:0]   bnd,
  input  logic          bnd_en,
  input  logic          code_new,
  output logic          h_gnt,
  output logic          seq_gnt,
  output logic          cmd_valid,
  output logic          cmd_we,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  output logic          cmd_newcode,
  output logic          cmd_lock,
  output logic          cmd_seq
);
  logic h_code, s_code;

  // Host priority outside a locked pair; inside it only the sequencer runs.
  assign h_gnt   = h_req && !lock;
  assign seq_gnt = seq_req && (lock || !h_req);

  assign h_code = bnd_en ? ({1'b0, h_addr} < bnd) : code_new;
  assign s_code = seq_we ? 1'b1 : (bnd_en ? ({1'b0, seq_addr} < bnd) : code_new);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid   <= 1'b0;
      cmd_we      <= 1'b0;
      cmd_addr    <= '0;
      cmd_wdata   <= '0;
      cmd_newcode <= 1'b0;
      cmd_lock    <= 1'b0;
      cmd_seq     <= 1'b0;
    end else begin
      cmd_valid <= h_gnt || seq_gnt;
      if (h_gnt) begin
        cmd_we      <= h_we;
        cmd_addr    <= h_addr;
        cmd_wdata   <= h_wdata;
        cmd_newcode <= h_code;
        cmd_lock    <= 1'b0;
        cmd_seq     <= 1'b0;
      end else if (seq_gnt) begin
        cmd_we      <= seq_we;
        cmd_addr    <= seq_addr;
        cmd_wdata   <= seq_wdata;
        cmd_newcode <= s_code;
        cmd_lock    <= 1'b1;
        cmd_seq     <= 1'b1;
      end
    end
  end

  // R6
  lock_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lock) && cmd_valid) |-> cmd_seq);

  // R5
  seq_wr_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_seq && cmd_we) |-> (cmd_newcode && cmd_lock));
endmodule

// File: rtl/code_boundary_regen.sv
`timescale 1ns/1ps
module code_boundary_regen #(
  parameter int AW       = 10,
  parameter int DW       = 64,
  parameter int LW       = 3,
  parameter int TOP_ADDR = (1 << AW) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_lane,
  input  logic [AW-1:0] cfg_bnd,
  input  logic          cfg_bnd_en,
  input  logic          cfg_upd_en,
  input  logic          cfg_ce_mask,
  input  logic          cfg_code_new,
  input  logic          h_req,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic          h_gnt,
  output logic          h_rsp_valid,
  output logic [DW-1:0] h_rdata,
  output logic          mem_cmd_valid,
  output logic          mem_cmd_we,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [DW-1:0] mem_cmd_wdata,
  output logic          mem_cmd_newcode,
  output logic          mem_cmd_lock,
  output logic          mem_cmd_seq,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_seq,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic          mem_rsp_ce,
  output logic [LW-1:0] lane_sel,
  output logic [AW:0]   boundary,
  output logic          regen_done,
  output logic          regen_irq,
  output logic          ce_irq
);
  cbr_pkg::cbr_mode_t cfg_mode;
  logic          bnd_en, code_new, ce_mask, active, adv;
  logic          s_req, s_we, s_lock, s_gnt;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;

  always_comb begin
    cfg_mode.bnd_en   = cfg_bnd_en;
    cfg_mode.upd_en   = cfg_upd_en;
    cfg_mode.ce_mask  = cfg_ce_mask;
    cfg_mode.code_new = cfg_code_new;
  end

  cbr_cfg_reg #(.AW(AW), .LW(LW), .TOP_ADDR(TOP_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_bnd(cfg_bnd),
    .cfg_mode(cfg_mode), .adv(adv), .lane_sel(lane_sel), .bnd(boundary),
    .bnd_en(bnd_en), .code_new(code_new), .ce_mask(ce_mask),
    .done(regen_done), .done_irq(regen_irq), .active(active)
  );

  cbr_regen_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .abort(cfg_we), .active(active), .bnd_lo(boundary[AW-1:0]),
    .gnt(s_gnt), .rsp_valid(mem_rsp_valid), .rsp_seq(mem_rsp_seq), .rsp_data(mem_rsp_rdata),
    .req(s_req), .req_we(s_we), .req_addr(s_addr), .req_wdata(s_wdata),
    .lock(s_lock), .adv(adv)
  );

  cbr_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .seq_req(s_req), .seq_we(s_we), .seq_addr(s_addr), .seq_wdata(s_wdata),
    .lock(s_lock), .bnd(boundary), .bnd_en(bnd_en), .code_new(code_new),
    .h_gnt(h_gnt), .seq_gnt(s_gnt), .cmd_valid(mem_cmd_valid), .cmd_we(mem_cmd_we),
    .cmd_addr(mem_cmd_addr), .cmd_wdata(mem_cmd_wdata), .cmd_newcode(mem_cmd_newcode),
    .cmd_lock(mem_cmd_lock), .cmd_seq(mem_cmd_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rsp_valid <= 1'b0;
      h_rdata     <= '0;
      ce_irq      <= 1'b0;
    end else begin
      h_rsp_valid <= mem_rsp_valid && !mem_rsp_seq;
      if (mem_rsp_valid && !mem_rsp_seq) h_rdata <= mem_rsp_rdata;
      ce_irq      <= mem_rsp_valid && mem_rsp_ce && !ce_mask;
    end
  end

  // R10
  ce_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ce_irq |-> ($past(mem_rsp_ce) && !$past(ce_mask)));
endmodule

// File: tb/code_boundary_regen_test.sv
`timescale 1ns/1ps
module code_boundary_regen_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LW = 3;
  localparam int NW = 1 << AW;
  localparam int LOGN = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cfg_we = 0, cfg_bnd_en = 0, cfg_upd_en = 0, cfg_ce_mask = 0, cfg_code_new = 0;
  logic [LW-1:0] cfg_lane = '0;
  logic [AW-1:0] cfg_bnd = '0;
  logic          h_req = 0, h_we = 0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic          h_gnt, h_rsp_valid;
  logic [DW-1:0] h_rdata;
  logic          mem_cmd_valid, mem_cmd_we, mem_cmd_newcode, mem_cmd_lock, mem_cmd_seq;
  logic [AW-1:0] mem_cmd_addr;
  logic [DW-1:0] mem_cmd_wdata;
  logic          mem_rsp_valid = 0, mem_rsp_seq = 0, mem_rsp_ce = 0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic [LW-1:0] lane_sel;
  logic [AW:0]   boundary;
  logic          regen_done, regen_irq, ce_irq;

  code_boundary_regen #(.AW(AW), .DW(DW), .LW(LW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_bnd(cfg_bnd),
    .cfg_bnd_en(cfg_bnd_en), .cfg_upd_en(cfg_upd_en), .cfg_ce_mask(cfg_ce_mask),
    .cfg_code_new(cfg_code_new), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_gnt(h_gnt), .h_rsp_valid(h_rsp_valid), .h_rdata(h_rdata),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_wdata(mem_cmd_wdata), .mem_cmd_newcode(mem_cmd_newcode),
    .mem_cmd_lock(mem_cmd_lock), .mem_cmd_seq(mem_cmd_seq), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_seq(mem_rsp_seq), .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_ce(mem_rsp_ce),
    .lane_sel(lane_sel), .boundary(boundary), .regen_done(regen_done),
    .regen_irq(regen_irq), .ce_irq(ce_irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mdata [NW];
  logic          mcode [NW];
  logic [DW-1:0] exp_data [NW];
  logic          lg_we [LOGN], lg_code [LOGN], lg_lock [LOGN], lg_seq [LOGN];
  logic [AW-1:0] lg_addr [LOGN];
  logic [DW-1:0] lg_wdata [LOGN];
  int log_n = 0, mism = 0, ce_cnt = 0, irq_cnt = 0;
  logic last_h_code = 0;
  logic inject_ce = 0;

  // Memory model and monitor, acting at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      mem_rsp_valid = 0;
      mem_rsp_ce = 0;
      if (ce_irq) ce_cnt++;
      if (regen_irq) irq_cnt++;
      if (mem_cmd_valid) begin
        if (log_n < LOGN) begin
          lg_we[log_n] = mem_cmd_we;     lg_code[log_n] = mem_cmd_newcode;
          lg_lock[log_n] = mem_cmd_lock; lg_seq[log_n] = mem_cmd_seq;
          lg_addr[log_n] = mem_cmd_addr; lg_wdata[log_n] = mem_cmd_wdata;
          log_n++;
        end
        if (!mem_cmd_seq) last_h_code = mem_cmd_newcode;
        if (mem_cmd_we) begin
          mdata[mem_cmd_addr] = mem_cmd_wdata;
          mcode[mem_cmd_addr] = mem_cmd_newcode;
        end else begin
          mem_rsp_valid = 1;
          mem_rsp_seq = mem_cmd_seq;
          mem_rsp_rdata = mdata[mem_cmd_addr];
          mem_rsp_ce = inject_ce;
          if (mcode[mem_cmd_addr] != mem_cmd_newcode) mism++;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int lane, input int bnd, input bit en, input bit upd,
                           input bit mask, input bit cn);
    @(negedge clk);
    cfg_we = 1; cfg_lane = LW'(lane); cfg_bnd = AW'(bnd);
    cfg_bnd_en = en; cfg_upd_en = upd; cfg_ce_mask = mask; cfg_code_new = cn;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic host_issue(input bit we, input int addr, input int data);
    bit got = 0;
    @(negedge clk);
    h_req = 1; h_we = we; h_addr = AW'(addr); h_wdata = DW'(data);
    while (!got) begin
      #1;
      got = h_gnt;
      @(negedge clk);
    end
    h_req = 0;
    #1;
  endtask

  task automatic host_wr(input int addr, input int data);
    host_issue(1'b1, addr, data);
    exp_data[addr] = DW'(data);
  endtask

  task automatic host_rd(input int addr, output int data);
    host_issue(1'b0, addr, 0);
    while (!h_rsp_valid) begin
      @(negedge clk);
      #1;
    end
    data = int'(h_rdata);
  endtask

  task automatic t_reset;
    chk("R1 boundary", int'(boundary), 0);
    chk("R1 cmd_valid", int'(mem_cmd_valid), 0);
    chk("R1 lane_sel", int'(lane_sel), 0);
    chk("R1 done/irqs", int'({regen_done, regen_irq, ce_irq}), 0);
  endtask

  task automatic t_prefill_global;
    for (int i = 0; i < NW; i++) host_wr(i, 'hA000 + i);
    chk("R4 old global code", int'(last_h_code), 0);
    cfg_write(0, 0, 0, 0, 0, 1);
    host_wr(7, 'hB007);
    chk("R4 new global code", int'(last_h_code), 1);
    cfg_write(0, 0, 0, 0, 0, 0);
    host_wr(7, 'hA007);
    chk("R4 back to old code", int'(last_h_code), 0);
  endtask

  task automatic t_cfg_boundary;
    cfg_write(3, 6, 1, 0, 1, 0);
    chk("R2 lane_sel loaded", int'(lane_sel), 3);
    chk("R2 boundary loaded", int'(boundary), 6);
    host_wr(5, 'hC005);
    chk("R3 below boundary new code", int'(last_h_code), 1);
    host_wr(6, 'hC006);
    chk("R3 at boundary old code", int'(last_h_code), 0);
    host_wr(10, 'hC00A);
    chk("R3 above boundary old code", int'(last_h_code), 0);
    cfg_write(0, 0, 0, 0, 0, 0);
    host_wr(5, 'hA005);
    chk("R2 later write restores global", int'(last_h_code), 0);
  endtask

  task automatic t_regen;
    int start, cnt, rd, nwr, hmid, first_s, last_s, prev_addr;
    bit ord_ok;
    start = log_n;
    mism = 0;
    irq_cnt = 0;
    cnt = ce_cnt;
    cfg_write(2, 0, 1, 1, 1, 0);
    fork
      begin
        host_wr(15, 'h5A5A);
        chk("R11 write above moving boundary", int'(last_h_code), 0);
        inject_ce = 1;
        host_rd(9, rd);
        inject_ce = 0;
        chk("R9 host read during regen", rd, int'(exp_data[9]));
        while (boundary < 5) @(negedge clk);
        host_wr(2, 'h2222);
        chk("R11 write below moving boundary", int'(last_h_code), 1);
      end
      begin
        int w = 0;
        while (!regen_done && w < 3000) begin @(negedge clk); w++; end
      end
    join
    chk("R10 masked ce raises nothing", ce_cnt - cnt, 0);
    chk("R8 done flag", int'(regen_done), 1);
    repeat (20) @(negedge clk);
    #1;
    chk("R8 single irq", irq_cnt, 1);
    chk("R8 boundary past top", int'(boundary), NW);
    chk("R2 lane_sel kept", int'(lane_sel), 2);
    // Scan the command log of this run.
    ord_ok = 1; nwr = 0; hmid = 0; first_s = -1; last_s = -1; prev_addr = -1;
    for (int i = start; i < log_n; i++) begin
      if (lg_seq[i]) begin
        if (first_s < 0) first_s = i;
        last_s = i;
        if (!lg_we[i]) begin
          if (i + 1 >= log_n || !lg_seq[i+1] || !lg_we[i+1] || lg_addr[i+1] != lg_addr[i]
              || !lg_lock[i+1] || !lg_code[i+1] || lg_code[i]) ord_ok = 0;
        end else begin
          nwr++;
          if (int'(lg_addr[i]) != prev_addr + 1) ord_ok = 0;
          prev_addr = int'(lg_addr[i]);
        end
      end
    end
    for (int i = first_s; i >= 0 && i < last_s; i++) if (!lg_seq[i]) hmid++;
    chk("R5 R6 locked pairs with no host between", int'(ord_ok), 1);
    chk("R7 write-back count ascending", nwr, NW);
    chk("R9 host interleaved between words", int'(hmid > 0), 1);
    chk("R5 reads used matching code", mism, 0);
    for (int i = 0; i < NW; i++) begin
      chk("R5 data preserved", int'(mdata[i]), int'(exp_data[i]));
      chk("R5 word now in new code", int'(mcode[i]), 1);
    end
  endtask

  task automatic t_finish_unmasked;
    int rd, c0;
    cfg_write(0, 0, 0, 0, 0, 1);
    c0 = ce_cnt;
    inject_ce = 1;
    host_rd(4, rd);
    inject_ce = 0;
    @(negedge clk);
    #1;
    chk("R10 unmasked ce pulses once", ce_cnt - c0, 1);
    chk("R4 R10 read data", rd, int'(exp_data[4]));
    chk("R4 new global code on read", int'(last_h_code), 1);
  endtask

  task automatic t_cancel;
    int mark, extra, w;
    cfg_write(0, 0, 1, 1, 1, 0);
    w = 0;
    while (boundary < 3 && w < 500) begin @(negedge clk); w++; end
    cfg_write(0, 8, 1, 0, 1, 0);
    mark = log_n;
    repeat (30) @(negedge clk);
    #1;
    extra = 0;
    for (int i = mark; i < log_n; i++) if (lg_seq[i]) extra++;
    chk("R12 boundary holds loaded value", int'(boundary), 8);
    chk("R12 no sequencer commands", extra, 0);
    chk("R12 done cleared by cfg write", int'(regen_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin mdata[i] = '0; mcode[i] = 0; exp_data[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    t_reset();
    t_prefill_global();
    t_cfg_boundary();
    t_regen();
    t_finish_unmasked();
    t_cancel();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule